// File: doc/BRIEF.md
# Pixel Upsampling Clock-Crossing Formatter

This block takes RGB pixel words that arrive in a slow input clock domain and delivers them in a faster output pixel clock domain. A static rate selection produces one, two or four output pixels for every input pixel. The extra output positions are either copies of the pixel or, when interpolation is enabled, the rounded per-channel mean of the pixel and its predecessor. A four-entry asynchronous FIFO with Gray-coded pointers carries the pixels across the clock boundary.

The FIFO is flushed at every field start and while an explicit initialisation request is held. On the output side a small state machine drains the FIFO. `ST_WAIT` emits nothing until a pixel is present; the transition `WAIT->RUN` pops the first pixel. `ST_RUN` steps a slot counter through the output positions of the current pixel. At the last slot, `RUN->RUN` pops the next pixel, while `RUN->STARVE` is taken when the FIFO is empty. `ST_STARVE` keeps repeating the last pixel and raises a sticky underflow flag; `STARVE->RUN` pops again once data returns. A flush forces `any->WAIT`.

When input and output clocks are the same, a bypass mode sends the input straight to the output through one register stage. This serves high input data rates, where the FIFO round trip is too slow.

Top module: `pix_upsample_xfmt`

## Requirements
- R1: After reset, `out_valid` and `underflow` are low.
- R2: With `rate_sel` = 2'd1 (x2) and interpolation off, every input pixel appears on two consecutive valid output cycles, in input order, with none lost or duplicated.
- R3: With `rate_sel` = 2'd2 or 2'd3 (x4) and interpolation off, every input pixel appears on four consecutive valid output cycles, in order.
- R4: With x2 and `interp_en` = 1, each input pixel is preceded by one inserted pixel. The inserted pixel is the per-channel mean (a+b+1)>>1 of the previous and current pixel, with channels at bits [23:16], [15:8] and [7:0]. The first pixel after a flush is averaged with itself.
- R5: With x4 and `interp_en` = 1, each input pixel is preceded by three inserted pixels, each equal to the rounded mean defined in R4.
- R6: With `bypass` = 1 (clocks equal), `out_pix` and `out_valid` equal `in_pix` and `in_valid` one output clock later, whatever `rate_sel` and `interp_en` are.
- R7: Once output has started, an empty FIFO makes the block keep `out_valid` high and repeat the last input pixel. It also sets `underflow`, which then stays set.
- R8: A `field_start` pulse flushes the FIFO. Afterwards `underflow` is low and `out_valid` is low until new pixels arrive.
- R9: While `init_req` is high, `out_valid` is low and input pixels are discarded, so none of them appears after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_clk | input | 1 | Input pixel clock |
| in_rst_n | input | 1 | Asynchronous active-low reset, input domain |
| in_valid | input | 1 | Input pixel qualifier |
| in_pix | input | 24 | Input RGB pixel (R high byte) |
| field_start | input | 1 | One-cycle field start pulse, input domain |
| out_clk | input | 1 | Output pixel clock |
| out_rst_n | input | 1 | Asynchronous active-low reset, output domain |
| init_req | input | 1 | Level request to flush and hold the FIFO, any domain |
| rate_sel | input | 2 | Output rate: 0 x1, 1 x2, 2 and 3 x4 |
| interp_en | input | 1 | Use rounded mean for inserted positions |
| bypass | input | 1 | Route input around the FIFO (equal clocks) |
| out_valid | output | 1 | Output pixel qualifier |
| out_pix | output | 24 | Output RGB pixel |
| underflow | output | 1 | Sticky FIFO underflow flag |

## Verification
The streams use pixel values whose channel sums are odd and cross byte boundaries. This makes rounding up distinguishable from truncation, and a swapped pair of channels distinguishable from the correct order. The same sequence is played at x2 and at x4, first with repetition and then with interpolation. This separates a wrong slot count, a wrong insertion order, a missing self-average on the first pixel, and a lost or doubled FIFO entry. Each stream is left to run dry, which exposes the starvation repeat and the sticky flag. A field start and a held init request then show that stale pixels and the flag are cleared. A bypass run with x4 and interpolation selected shows that both settings are ignored on the direct path.

// File: rtl/ufmt_pkg.sv
package ufmt_pkg;

    typedef enum logic [1:0] {
        ST_WAIT   = 2'd0,
        ST_RUN    = 2'd1,
        ST_STARVE = 2'd2
    } rd_state_e;

    // rate_sel encoding: 0 -> x1, 1 -> x2, 2 and 3 -> x4
    function automatic logic [1:0] last_slot(input logic [1:0] rate_sel);
        unique case (rate_sel)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/ufmt_sync.sv
module ufmt_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else if (clr) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/ufmt_flush_ctl.sv
module ufmt_flush_ctl #(
    parameter int FLUSH_CYC = 4
) (
    input  logic in_clk,
    input  logic in_rst_n,
    input  logic field_start,
    input  logic out_clk,
    input  logic out_rst_n,
    input  logic init_req,
    output logic whold,
    output logic rhold
);
    localparam int CW = $clog2(FLUSH_CYC + 1);

    logic          init_w;
    logic [CW-1:0] stretch_q;
    logic          hold_lvl_q;

    ufmt_sync #(.W(1)) u_init_w (
        .clk(in_clk), .rst_n(in_rst_n), .clr(1'b0), .d(init_req), .q(init_w)
    );

    always_ff @(posedge in_clk or negedge in_rst_n) begin
        if (!in_rst_n) begin
            stretch_q <= '0;
        end else if (field_start) begin
            stretch_q <= CW'(FLUSH_CYC);
        end else if (stretch_q != '0) begin
            stretch_q <= stretch_q - 1'b1;
        end
    end

    assign whold = init_w || field_start || (stretch_q != '0);

    always_ff @(posedge in_clk or negedge in_rst_n) begin
        if (!in_rst_n) hold_lvl_q <= 1'b0;
        else           hold_lvl_q <= whold;
    end

    ufmt_sync #(.W(1)) u_hold_r (
        .clk(out_clk), .rst_n(out_rst_n), .clr(1'b0), .d(hold_lvl_q), .q(rhold)
    );

    AST_FIELD_HOLD: assert property (@(posedge in_clk) disable iff (!in_rst_n)
        field_start |=> whold) else $error("field start did not hold writer"); // R8
endmodule

// File: rtl/ufmt_afifo.sv
module ufmt_afifo #(
    parameter int DATA_W = 24,
    parameter int AW     = 2
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              whold,
    input  logic              wvalid,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic              rhold,
    input  logic              rpop,
    output logic              rempty,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    localparam int PW    = AW + 1;

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [DATA_W-1:0] mem [DEPTH];

    // write domain
    logic [PW-1:0] wbin_q, wgray_q, rgray_w;
    logic          wfull, wpush;

    assign wfull = (wgray_q == {~rgray_w[PW-1 -: 2], rgray_w[PW-3:0]});
    assign wpush = wvalid && !wfull && !whold;

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) begin
            wbin_q  <= '0;
            wgray_q <= '0;
        end else if (whold) begin
            wbin_q  <= '0;
            wgray_q <= '0;
        end else if (wpush) begin
            wbin_q  <= wbin_q + 1'b1;
            wgray_q <= to_gray(wbin_q + 1'b1);
        end
    end

    always_ff @(posedge wclk) begin
        if (wpush) mem[wbin_q[AW-1:0]] <= wdata;
    end

    // read domain
    logic [PW-1:0] rbin_q, rgray_q, wgray_r;

    ufmt_sync #(.W(PW)) u_r2w (
        .clk(wclk), .rst_n(wrst_n), .clr(whold), .d(rgray_q), .q(rgray_w)
    );
    ufmt_sync #(.W(PW)) u_w2r (
        .clk(rclk), .rst_n(rrst_n), .clr(rhold), .d(wgray_q), .q(wgray_r)
    );

    assign rempty = (rgray_q == wgray_r);
    assign rdata  = mem[rbin_q[AW-1:0]];

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            rbin_q  <= '0;
            rgray_q <= '0;
        end else if (rhold) begin
            rbin_q  <= '0;
            rgray_q <= '0;
        end else if (rpop && !rempty) begin
            rbin_q  <= rbin_q + 1'b1;
            rgray_q <= to_gray(rbin_q + 1'b1);
        end
    end

    AST_GRAY_STEP: assert property (@(posedge wclk) disable iff (!wrst_n)
        !whold |=> ($countones(wgray_q ^ $past(wgray_q)) <= 1)) else $error("write pointer not gray"); // R2
    AST_NO_OVERFLOW: assert property (@(posedge rclk) disable iff (!rrst_n || rhold)
        ((from_gray(wgray_r) - rbin_q) <= PW'(DEPTH))) else $error("occupancy beyond depth"); // R2
    AST_RPTR_FLUSH: assert property (@(posedge rclk) disable iff (!rrst_n)
        rhold |=> (rbin_q == '0)) else $error("read pointer not cleared"); // R8
endmodule

// File: rtl/ufmt_upsampler.sv
module ufmt_upsampler
    import ufmt_pkg::*;
#(
    parameter int CH_W = 8,
    parameter int NCH  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hold,
    input  logic [1:0]          rate_sel,
    input  logic                interp_en,
    input  logic                empty,
    input  logic [NCH*CH_W-1:0] rdata,
    output logic                pop,
    output logic                out_valid,
    output logic [NCH*CH_W-1:0] out_pix,
    output logic                underflow
);
    localparam int PIX_W = NCH * CH_W;

    rd_state_e        state_q;
    logic [1:0]       slot_q;
    logic [PIX_W-1:0] cur_q, prev_q, mean;
    logic [1:0]       last;
    logic             at_last;

    assign last    = last_slot(rate_sel);
    assign at_last = (slot_q == last);

    for (genvar c = 0; c < NCH; c++) begin : g_mean
        logic [CH_W:0] sum;
        assign sum = {1'b0, prev_q[c*CH_W +: CH_W]} + {1'b0, cur_q[c*CH_W +: CH_W]} + 1'b1;
        assign mean[c*CH_W +: CH_W] = sum[CH_W:1];
    end

    always_comb begin
        pop = 1'b0;
        if (!hold && !empty) begin
            unique case (state_q)
                ST_WAIT:   pop = 1'b1;
                ST_RUN:    pop = at_last;
                ST_STARVE: pop = 1'b1;
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_WAIT;
            slot_q    <= '0;
            cur_q     <= '0;
            prev_q    <= '0;
            underflow <= 1'b0;
        end else if (hold) begin
            state_q   <= ST_WAIT;
            slot_q    <= '0;
            cur_q     <= '0;
            prev_q    <= '0;
            underflow <= 1'b0;
        end else begin
            unique case (state_q)
                ST_WAIT: begin
                    if (pop) begin
                        cur_q   <= rdata;
                        prev_q  <= rdata;
                        slot_q  <= '0;
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (!at_last) begin
                        slot_q <= slot_q + 1'b1;
                    end else if (pop) begin
                        prev_q <= cur_q;
                        cur_q  <= rdata;
                        slot_q <= '0;
                    end else begin
                        state_q   <= ST_STARVE;
                        underflow <= 1'b1;
                    end
                end
                ST_STARVE: begin
                    if (pop) begin
                        prev_q  <= cur_q;
                        cur_q   <= rdata;
                        slot_q  <= '0;
                        state_q <= ST_RUN;
                    end
                end
            endcase
        end
    end

    // output process
    always_comb begin
        out_valid = 1'b0;
        out_pix   = '0;
        unique case (state_q)
            ST_WAIT: begin
                out_valid = 1'b0;
            end
            ST_RUN: begin
                out_valid = 1'b1;
                out_pix   = (interp_en && !at_last) ? mean : cur_q;
            end
            ST_STARVE: begin
                out_valid = 1'b1;
                out_pix   = cur_q;
            end
        endcase
    end

    AST_UFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !hold) |=> underflow) else $error("underflow flag dropped"); // R7
    AST_STARVE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STARVE) |-> underflow) else $error("starving without flag"); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !out_valid) else $error("output during hold"); // R9
endmodule

// File: rtl/pix_upsample_xfmt.sv
module pix_upsample_xfmt #(
    parameter int CH_W      = 8,
    parameter int NCH       = 3,
    parameter int AW        = 2,
    parameter int FLUSH_CYC = 4
) (
    input  logic                in_clk,
    input  logic                in_rst_n,
    input  logic                in_valid,
    input  logic [NCH*CH_W-1:0] in_pix,
    input  logic                field_start,
    input  logic                out_clk,
    input  logic                out_rst_n,
    input  logic                init_req,
    input  logic [1:0]          rate_sel,
    input  logic                interp_en,
    input  logic                bypass,
    output logic                out_valid,
    output logic [NCH*CH_W-1:0] out_pix,
    output logic                underflow
);
    localparam int PIX_W = NCH * CH_W;

    logic             whold, rhold, empty, pop, ups_valid;
    logic [PIX_W-1:0] rdata, ups_pix, byp_pix_q;
    logic             byp_valid_q;

    ufmt_flush_ctl #(.FLUSH_CYC(FLUSH_CYC)) u_flush (
        .in_clk(in_clk), .in_rst_n(in_rst_n), .field_start(field_start),
        .out_clk(out_clk), .out_rst_n(out_rst_n), .init_req(init_req),
        .whold(whold), .rhold(rhold)
    );

    ufmt_afifo #(.DATA_W(PIX_W), .AW(AW)) u_fifo (
        .wclk(in_clk), .wrst_n(in_rst_n), .whold(whold),
        .wvalid(in_valid && !bypass), .wdata(in_pix),
        .rclk(out_clk), .rrst_n(out_rst_n), .rhold(rhold),
        .rpop(pop), .rempty(empty), .rdata(rdata)
    );

    ufmt_upsampler #(.CH_W(CH_W), .NCH(NCH)) u_ups (
        .clk(out_clk), .rst_n(out_rst_n), .hold(rhold),
        .rate_sel(rate_sel), .interp_en(interp_en),
        .empty(empty), .rdata(rdata), .pop(pop),
        .out_valid(ups_valid), .out_pix(ups_pix), .underflow(underflow)
    );

    always_ff @(posedge out_clk or negedge out_rst_n) begin
        if (!out_rst_n) begin
            byp_valid_q <= 1'b0;
            byp_pix_q   <= '0;
        end else begin
            byp_valid_q <= in_valid;
            byp_pix_q   <= in_pix;
        end
    end

    assign out_valid = bypass ? byp_valid_q : ups_valid;
    assign out_pix   = bypass ? byp_pix_q   : ups_pix;

    AST_BYPASS_PASS: assert property (@(posedge out_clk) disable iff (!out_rst_n)
        (bypass && $past(bypass)) |-> (out_pix == $past(in_pix))) else $error("bypass mismatch"); // R6
endmodule

// File: tb/pix_upsample_xfmt_tb_top.sv
module pix_upsample_xfmt_tb_top;
    logic        out_clk = 1'b0;
    logic        in_clk;
    logic        in_rst_n = 1'b0, out_rst_n = 1'b0;
    logic        in_valid = 1'b0, field_start = 1'b0, init_req = 1'b0;
    logic [23:0] in_pix = '0;
    logic [1:0]  rate_sel = 2'd1;
    logic        interp_en = 1'b0, bypass = 1'b0;
    logic        out_valid, underflow;
    logic [23:0] out_pix;

    int          div = 1;
    logic [1:0]  dcnt = '0;
    int          checks = 0, errors = 0;

    logic [23:0] cap [256];
    int          cap_n = 0;
    logic        cap_en = 1'b0;

    always #2 out_clk = ~out_clk;
    always @(posedge out_clk) dcnt <= dcnt + 1'b1;
    assign in_clk = (div == 1) ? out_clk : ((div == 2) ? dcnt[0] : dcnt[1]);

    pix_upsample_xfmt dut_i (
        .in_clk(in_clk), .in_rst_n(in_rst_n), .in_valid(in_valid), .in_pix(in_pix),
        .field_start(field_start), .out_clk(out_clk), .out_rst_n(out_rst_n),
        .init_req(init_req), .rate_sel(rate_sel), .interp_en(interp_en),
        .bypass(bypass), .out_valid(out_valid), .out_pix(out_pix), .underflow(underflow)
    );

    always @(negedge out_clk) begin
        if (cap_en && out_valid && cap_n < 256) begin
            cap[cap_n] = out_pix;
            cap_n = cap_n + 1;
        end
    end

    function automatic logic [23:0] pix(input int base, input int i);
        return {8'(base + i * 37), 8'(base * 3 + i * 11 + 5), 8'(250 - i * 53)};
    endfunction

    function automatic logic [23:0] mean(input logic [23:0] a, input logic [23:0] b);
        logic [23:0] r;
        for (int c = 0; c < 3; c++) begin
            logic [8:0] s;
            s = {1'b0, a[c*8 +: 8]} + {1'b0, b[c*8 +: 8]} + 9'd1;
            r[c*8 +: 8] = s[8:1];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_out(input int n);
        repeat (n) @(negedge out_clk);
    endtask

    task automatic send(input int base, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge in_clk);
            in_valid = 1'b1;
            in_pix   = pix(base, i);
        end
        @(negedge in_clk);
        in_valid = 1'b0;
    endtask

    task automatic reconfig(input int f, input logic [1:0] rs, input logic ip);
        init_req = 1'b1;
        wait_out(12);
        div = f; rate_sel = rs; interp_en = ip;
        wait_out(12);
        init_req = 1'b0;
        wait_out(30);
    endtask

    // plays n pixels and checks the stream, then the starvation state
    task automatic t_stream(input string req, input int f, input logic [1:0] rs,
                            input logic ip, input int base);
        logic [23:0] cur, prv;
        int          k;
        reconfig(f, rs, ip);
        cap_n  = 0;
        cap_en = 1'b1;
        send(base, 6);
        wait_out(6 * f + 40);
        cap_en = 1'b0;
        k = 0;
        for (int i = 0; i < 6; i++) begin
            cur = pix(base, i);
            prv = (i == 0) ? cur : pix(base, i - 1);
            for (int s = 0; s < f; s++) begin
                check(req, {8'h0, cap[k]}, {8'h0, (ip && s != f - 1) ? mean(prv, cur) : cur});
                k++;
            end
        end
        // R7: starvation repeats the last pixel and sets the sticky flag
        check("R7 valid", {31'h0, out_valid}, 32'h1);
        check("R7 pixel", {8'h0, out_pix}, {8'h0, pix(base, 5)});
        check("R7 flag", {31'h0, underflow}, 32'h1);
        wait_out(10);
        check("R7 sticky", {31'h0, underflow}, 32'h1);
    endtask

    task automatic t_reset();
        check("R1 valid", {31'h0, out_valid}, 32'h0);
        check("R1 flag", {31'h0, underflow}, 32'h0);
    endtask

    task automatic t_field();
        @(negedge in_clk) field_start = 1'b1;
        @(negedge in_clk) field_start = 1'b0;
        wait_out(40);
        check("R8 flag", {31'h0, underflow}, 32'h0);
        check("R8 valid", {31'h0, out_valid}, 32'h0);
        cap_n  = 0;
        cap_en = 1'b1;
        send(90, 2);
        wait_out(30);
        cap_en = 1'b0;
        check("R8 first", {8'h0, cap[0]}, {8'h0, pix(90, 0)});
    endtask

    task automatic t_init();
        init_req = 1'b1;
        wait_out(12);
        send(60, 4);
        check("R9 held", {31'h0, out_valid}, 32'h0);
        init_req = 1'b0;
        wait_out(40);
        check("R9 discarded", {31'h0, out_valid}, 32'h0);
        check("R9 flag", {31'h0, underflow}, 32'h0);
    endtask

    task automatic t_bypass();
        reconfig(1, 2'd2, 1'b1);
        bypass = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge out_clk);
            if (i > 0) begin
                check("R6 pix", {8'h0, out_pix}, {8'h0, pix(120, i - 1)});
                check("R6 valid", {31'h0, out_valid}, 32'h1);
            end
            in_valid = 1'b1;
            in_pix   = pix(120, i);
        end
        @(negedge out_clk) in_valid = 1'b0;
        @(negedge out_clk);
        check("R6 idle", {31'h0, out_valid}, 32'h0);
        bypass = 1'b0;
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #400_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    initial begin
        div = 2;
        wait_out(6);
        in_rst_n = 1'b1; out_rst_n = 1'b1;
        wait_out(4);
        t_reset();
        t_stream("R2", 2, 2'd1, 1'b0, 10);
        t_field();
        t_stream("R3", 4, 2'd2, 1'b0, 30);
        t_stream("R3 sel3", 4, 2'd3, 1'b0, 33);
        t_stream("R4", 2, 2'd1, 1'b1, 70);
        t_stream("R5", 4, 2'd2, 1'b1, 140);
        t_init();
        t_bypass();
        finish_sim();
    end
endmodule